// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. A 16-bit down-counter is clocked by a tick. The tick is made from the system clock in two stages: an 8-bit programmable prescaler that divides by P+1, followed by a fixed post-divider that divides by 16, 32, 64 or 128. When the counter has reached zero, the next tick reloads it from a reload register and raises an expiry event. Depending on two enable bits, that event sets a sticky interrupt, starts a reset request lasting a fixed number of system clocks, or does both. Software keeps the system alive by rewriting the counter before it runs out. It acknowledges the interrupt by writing one to a clear register.

Four 32-bit word registers are decoded from a 4-bit byte address: control (0x0), reload (0x4), live counter (0x8) and interrupt clear (0xC). Control holds reset-enable at bit 0, interrupt-enable at bit 2, the post-divider select at bits [4:3], the run bit at bit 5 and the prescale value at bits [15:8]. All other control bits read as zero.

The counter is driven by a state machine with three states. HALT is left for COUNT or ARMED when run is set. COUNT goes to ARMED when a tick takes the counter from 1 to 0. ARMED returns to COUNT on the expiring tick, or stays in ARMED when the reload value is 0. Clearing run returns either running state to HALT. A counter write picks COUNT or ARMED from the written value. A second machine shapes the reset request. It goes from IDLE to HOLD on an expiry with reset enabled. It goes from HOLD back to IDLE after the hold time, and a new expiry during HOLD restarts the hold.

Top module: `wdt_top`

## Requirements
- R1: After reset, control reads 0, reload and counter read 0x8000, the interrupt output is low and the reset request is low.
- R2: Control reads back its written fields at bits 0, 2, [4:3], 5 and [15:8]; every other control bit reads 0; reload reads back the value written; the clear register at 0xC always reads 0.
- R3: While control bit 5 (run) is 0, the counter does not change except through a bus write to 0x8, which loads the low 16 bits of the write data.
- R4: While running, a tick occurs every (P+1)*D system clocks, where P is control bits [15:8] and D is the post-divider ratio. The first counter step lands (P+1)*D+1 clocks after the control write that sets run, and each tick lowers a nonzero counter by exactly one.
- R5: A tick that finds the counter at 0 reloads the counter from the reload register and produces one expiry event.
- R6: An expiry with interrupt-enable (bit 2) set makes the interrupt output high on the same clock edge that reloads the counter. The output stays high until it is cleared, and it is never set by an expiry while bit 2 is 0.
- R7: A write to 0xC with data bit 0 equal to 1 drops the interrupt output at that edge; a write with bit 0 equal to 0 leaves it unchanged.
- R8: Post-divider select encoding in bits [4:3]: 0 divides by 16, 1 by 32, 2 by 64, 3 by 128.
- R9: An expiry with reset-enable (bit 0) set raises the reset request on the reloading edge and holds it high for exactly 16 system clocks after the last such expiry.
- R10: Rewriting the counter before it expires restarts the countdown, so a regularly refreshed watchdog never requests a reset.
- R11: The reset request rises only when the previous cycle had both run and reset-enable set; a watchdog stopped by clearing run never requests a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address, bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | Reset request, held for 16 clocks |

## Verification
Some rules are checked by the assertions on every cycle:
- the counter only holds, steps down by one or reloads;
- it is frozen while stopped;
- the interrupt stays high until a clear write, and it only rises with interrupt-enable set;
- the reset request rises only with run and reset-enable set, and falls exactly the hold time after the last trigger.

The exact tick period for each prescale and divider setting, the cycle on which the reload lands, the read-back masking and reset values, and the effect of periodic refreshes can only be shown by the bench's timed scenarios.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Bus geometry
    localparam int unsigned REG_W   = 32;
    localparam int unsigned BUS_AW  = 4;

    // Timebase geometry
    localparam int unsigned PRE_W          = 8;
    localparam int unsigned DIVSEL_W       = 2;
    localparam int unsigned DIV_BASE_LOG2  = 4;
    localparam int unsigned DIV_OPTS       = 1 << DIVSEL_W;
    localparam int unsigned DIVCNT_W       = DIV_BASE_LOG2 + DIV_OPTS - 1;

    // Register word indices (address bits [3:2])
    localparam logic [1:0] IDX_CTRL   = 2'd0;
    localparam logic [1:0] IDX_RELOAD = 2'd1;
    localparam logic [1:0] IDX_COUNT  = 2'd2;
    localparam logic [1:0] IDX_ICLR   = 2'd3;

    // Control field positions
    localparam int unsigned B_RSTEN   = 0;
    localparam int unsigned B_IRQEN   = 2;
    localparam int unsigned B_DIVLSB  = 3;
    localparam int unsigned B_RUN     = 5;
    localparam int unsigned B_PRELSB  = 8;

    typedef struct packed {
        logic [PRE_W-1:0]    presc;
        logic                run;
        logic [DIVSEL_W-1:0] div_sel;
        logic                irq_en;
        logic                rst_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        CS_HALT  = 2'd0,
        CS_COUNT = 2'd1,
        CS_ARMED = 2'd2
    } core_state_e;

    typedef enum logic {
        RG_IDLE = 1'b0,
        RG_HOLD = 1'b1
    } rg_state_e;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned    CNT_W       = 16,
    parameter logic [15:0]    RESET_COUNT = 16'h8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [CNT_W-1:0]     count_i,
    output ctrl_t                ctrl_o,
    output logic [CNT_W-1:0]     reload_o,
    output logic                 cnt_wr_o,
    output logic [CNT_W-1:0]     cnt_wdata_o,
    output logic                 iclr_o
);

    logic [1:0]          word_sel;
    ctrl_t               ctrl_q;
    logic [CNT_W-1:0]    reload_q;
    logic                ctrl_wr;
    logic                reload_wr;
    logic                unused_wbits;

    assign word_sel  = bus_addr[3:2];
    assign ctrl_wr   = bus_wr && (word_sel == IDX_CTRL);
    assign reload_wr = bus_wr && (word_sel == IDX_RELOAD);
    assign cnt_wr_o  = bus_wr && (word_sel == IDX_COUNT);
    assign iclr_o    = bus_wr && (word_sel == IDX_ICLR) && bus_wdata[0];

    assign cnt_wdata_o = bus_wdata[CNT_W-1:0];

    assign unused_wbits = ^{bus_wdata[REG_W-1:B_PRELSB+PRE_W], bus_wdata[7:6],
                            bus_wdata[1], bus_addr[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.rst_en  <= bus_wdata[B_RSTEN];
            ctrl_q.irq_en  <= bus_wdata[B_IRQEN];
            ctrl_q.div_sel <= bus_wdata[B_DIVLSB +: DIVSEL_W];
            ctrl_q.run     <= bus_wdata[B_RUN];
            ctrl_q.presc   <= bus_wdata[B_PRELSB +: PRE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= CNT_W'(RESET_COUNT);
        end else if (reload_wr) begin
            reload_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (word_sel)
            IDX_CTRL: begin
                bus_rdata[B_RSTEN]                = ctrl_q.rst_en;
                bus_rdata[B_IRQEN]                = ctrl_q.irq_en;
                bus_rdata[B_DIVLSB +: DIVSEL_W]   = ctrl_q.div_sel;
                bus_rdata[B_RUN]                  = ctrl_q.run;
                bus_rdata[B_PRELSB +: PRE_W]      = ctrl_q.presc;
            end
            IDX_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
            IDX_COUNT:  bus_rdata[CNT_W-1:0] = count_i;
            IDX_ICLR:   bus_rdata = '0;
            default:    bus_rdata = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
    import wdt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic [PRE_W-1:0]     presc_i,
    input  logic [DIVSEL_W-1:0]  div_sel_i,
    output logic                 tick_o
);

    logic [PRE_W-1:0]    pre_q;
    logic [DIVCNT_W-1:0] div_q;
    logic                tick_q;
    logic [DIVCNT_W-1:0] last_tbl [DIV_OPTS];
    logic [DIVCNT_W-1:0] div_last;
    logic                pre_wrap;
    logic                div_wrap;

    // One terminal value per post-divider option: 2^(base+sel) - 1
    for (genvar g = 0; g < DIV_OPTS; g++) begin : g_div_last
        assign last_tbl[g] = DIVCNT_W'((1 << (DIV_BASE_LOG2 + g)) - 1);
    end

    assign div_last = last_tbl[div_sel_i];
    assign pre_wrap = (pre_q >= presc_i);
    assign div_wrap = (div_q >= div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            div_q  <= '0;
            tick_q <= 1'b0;
        end else if (!run_i) begin
            pre_q  <= '0;
            div_q  <= '0;
            tick_q <= 1'b0;
        end else if (pre_wrap) begin
            pre_q <= '0;
            if (div_wrap) begin
                div_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                div_q  <= div_q + 1'b1;
                tick_q <= 1'b0;
            end
        end else begin
            pre_q  <= pre_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter logic [15:0] RESET_COUNT = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              irq_en_i,
    input  logic              tick_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              iclr_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              fire_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    core_state_e       state_q, state_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic              irq_q;
    logic              fire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HALT: begin
                if (run_i) begin
                    if (cnt_wr_i) begin
                        state_d = (cnt_wdata_i == '0) ? CS_ARMED : CS_COUNT;
                    end else begin
                        state_d = (count_q == '0) ? CS_ARMED : CS_COUNT;
                    end
                end
            end
            CS_COUNT: begin
                if (!run_i) begin
                    state_d = CS_HALT;
                end else if (cnt_wr_i) begin
                    state_d = (cnt_wdata_i == '0) ? CS_ARMED : CS_COUNT;
                end else if (tick_i && (count_q == ONE)) begin
                    state_d = CS_ARMED;
                end
            end
            CS_ARMED: begin
                if (!run_i) begin
                    state_d = CS_HALT;
                end else if (cnt_wr_i) begin
                    state_d = (cnt_wdata_i == '0) ? CS_ARMED : CS_COUNT;
                end else if (tick_i) begin
                    state_d = (reload_i == '0) ? CS_ARMED : CS_COUNT;
                end
            end
            default: state_d = CS_HALT;
        endcase
    end

    // Output and datapath logic
    always_comb begin
        count_d = count_q;
        fire    = 1'b0;
        if (cnt_wr_i) begin
            count_d = cnt_wdata_i;
        end else begin
            unique case (state_q)
                CS_COUNT: begin
                    if (run_i && tick_i) begin
                        count_d = count_q - ONE;
                    end
                end
                CS_ARMED: begin
                    if (run_i && tick_i) begin
                        count_d = reload_i;
                        fire    = 1'b1;
                    end
                end
                default: count_d = count_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RESET_COUNT);
        end else begin
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (fire && irq_en_i) begin
            irq_q <= 1'b1;
        end else if (iclr_i) begin
            irq_q <= 1'b0;
        end
    end

    assign count_o = count_q;
    assign fire_o  = fire;
    assign irq_o   = irq_q;

endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen
    import wdt_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rst_req_o
);

    localparam int unsigned HW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    rg_state_e      state_q, state_d;
    logic [HW-1:0]  hold_q, hold_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RG_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        unique case (state_q)
            RG_IDLE: begin
                if (trig_i) begin
                    state_d = RG_HOLD;
                    hold_d  = HOLD_LAST;
                end
            end
            RG_HOLD: begin
                if (trig_i) begin
                    hold_d = HOLD_LAST;
                end else if (hold_q == '0) begin
                    state_d = RG_IDLE;
                end else begin
                    hold_d = hold_q - 1'b1;
                end
            end
            default: state_d = RG_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        rst_req_o = (state_q == RG_HOLD);
    end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned HOLD_CYCLES = 16,
    parameter logic [15:0] RESET_COUNT = 16'h8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        rst_req_o
);

    ctrl_t             ctrl_w;
    logic [CNT_W-1:0]  reload_w;
    logic [CNT_W-1:0]  count_w;
    logic [CNT_W-1:0]  cnt_wdata_w;
    logic              cnt_wr_w;
    logic              iclr_w;
    logic              tick_w;
    logic              fire_w;
    logic              run_w;
    logic              rst_en_w;
    logic              irq_en_w;

    assign run_w    = ctrl_w.run;
    assign rst_en_w = ctrl_w.rst_en;
    assign irq_en_w = ctrl_w.irq_en;

    wdt_regs #(
        .CNT_W       (CNT_W),
        .RESET_COUNT (RESET_COUNT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .count_i     (count_w),
        .ctrl_o      (ctrl_w),
        .reload_o    (reload_w),
        .cnt_wr_o    (cnt_wr_w),
        .cnt_wdata_o (cnt_wdata_w),
        .iclr_o      (iclr_w)
    );

    wdt_timebase u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_w),
        .presc_i   (ctrl_w.presc),
        .div_sel_i (ctrl_w.div_sel),
        .tick_o    (tick_w)
    );

    wdt_core #(
        .CNT_W       (CNT_W),
        .RESET_COUNT (RESET_COUNT)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_w),
        .irq_en_i    (irq_en_w),
        .tick_i      (tick_w),
        .cnt_wr_i    (cnt_wr_w),
        .cnt_wdata_i (cnt_wdata_w),
        .reload_i    (reload_w),
        .iclr_i      (iclr_w),
        .count_o     (count_w),
        .fire_o      (fire_w),
        .irq_o       (irq_o)
    );

    wdt_rstgen #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_rstgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (fire_w && rst_en_w),
        .rst_req_o (rst_req_o)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned HOLD_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              run,
    input logic              rst_en,
    input logic              irq_en,
    input logic              fire,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload,
    input logic              irq,
    input logic              rst_req
);

    localparam int unsigned SW = $clog2(HOLD_CYCLES + 2);
    localparam logic [SW-1:0] SAT = SW'(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic          cnt_wr;
    logic          clr_wr;
    logic [SW-1:0] since_trig;

    assign cnt_wr = bus_wr && (bus_addr[3:2] == IDX_COUNT);
    assign clr_wr = bus_wr && (bus_addr[3:2] == IDX_ICLR) && bus_wdata[0];

    // Cycles since the last reset-enabled expiry, saturating at the hold time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_trig <= SAT;
        end else if (fire && rst_en) begin
            since_trig <= '0;
        end else if (since_trig < SAT) begin
            since_trig <= since_trig + 1'b1;
        end
    end

    assert_count_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> (count == $past(count)));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ((count == $past(count)) || (count == $past(count) - ONE)
                     || (count == $past(reload))));

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));

    assert_rst_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (since_trig < SAT));

    assert_rst_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (since_trig == SAT));

    assert_rst_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(run && rst_en));

endmodule

bind wdt_top wdt_checker #(
    .CNT_W       (CNT_W),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_wdt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run_w),
    .rst_en    (rst_en_w),
    .irq_en    (irq_en_w),
    .fire      (fire_w),
    .count     (count_w),
    .reload    (reload_w),
    .irq       (irq_o),
    .rst_req   (rst_req_o)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_RLD  = 4'h4;
    localparam logic [3:0] A_CNT  = 4'h8;
    localparam logic [3:0] A_CLR  = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;
    int rst_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_top u_wdt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    always @(negedge clk) if (rst_req_o) rst_seen++;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 control after reset", v, 32'h0);
        rd(A_RLD, v);  chk("R1 reload after reset", v, 32'h8000);
        rd(A_CNT, v);  chk("R1 counter after reset", v, 32'h8000);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        chk("R1 reset request after reset", {31'b0, rst_req_o}, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_ABDD);
        rd(A_CTRL, v); chk("R2 control field masking", v, 32'h0000_AB1D);
        wr(A_RLD, 32'h1234_5A5A);
        rd(A_RLD, v);  chk("R2 reload readback", v, 32'h0000_5A5A);
        wr(A_CLR, 32'h0);
        rd(A_CLR, v);  chk("R2 clear register reads zero", v, 32'h0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_frozen();
        logic [31:0] v;
        wr(A_CNT, 32'hABCD_0005);
        rd(A_CNT, v); chk("R3 counter write loads low half", v, 32'h5);
        wait_edges(100);
        rd(A_CNT, v); chk("R3 counter frozen while stopped", v, 32'h5);
    endtask

    task automatic t_basic_expiry();
        logic [31:0] v;
        wr(A_RLD, 32'd3);
        wr(A_CNT, 32'd3);
        wr(A_CTRL, 32'h24);
        wait_edges(16);
        rd(A_CNT, v); chk("R4 no step before first tick", v, 32'd3);
        wait_edges(1);
        rd(A_CNT, v); chk("R4 first step after 17 clocks", v, 32'd2);
        wait_edges(47);
        rd(A_CNT, v); chk("R4 counter reaches zero", v, 32'd0);
        chk("R6 irq low before expiry", {31'b0, irq_o}, 32'h0);
        wait_edges(1);
        rd(A_CNT, v); chk("R5 reload on expiry", v, 32'd3);
        chk("R6 irq set on expiry", {31'b0, irq_o}, 32'h1);
        chk("R11 no reset without enable", {31'b0, rst_req_o}, 32'h0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_irq_clear();
        wr(A_CLR, 32'h0000_0002);
        chk("R7 clear with bit0 zero ignored", {31'b0, irq_o}, 32'h1);
        wait_edges(20);
        chk("R6 irq sticky", {31'b0, irq_o}, 32'h1);
        wr(A_CLR, 32'h1);
        chk("R7 clear drops irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(A_RLD, 32'd5);
        wr(A_CNT, 32'd1);
        wr(A_CTRL, 32'h22C);
        wait_edges(192);
        rd(A_CNT, v); chk("R4 prescale 2 div 32 at zero", v, 32'd0);
        chk("R4 prescale irq not yet", {31'b0, irq_o}, 32'h0);
        wait_edges(1);
        rd(A_CNT, v); chk("R5 prescale reload", v, 32'd5);
        chk("R4 prescale expiry edge", {31'b0, irq_o}, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h1);
    endtask

    task automatic t_div128();
        wr(A_RLD, 32'd7);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h3C);
        wait_edges(128);
        chk("R8 div128 before expiry", {31'b0, irq_o}, 32'h0);
        wait_edges(1);
        chk("R8 div128 expiry", {31'b0, irq_o}, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h1);
    endtask

    task automatic t_reset_pulse();
        int base;
        base = rst_seen;
        wr(A_RLD, 32'd2);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h21);
        wait_edges(16);
        chk("R9 reset low before expiry", {31'b0, rst_req_o}, 32'h0);
        wait_edges(1);
        chk("R9 reset high on expiry", {31'b0, rst_req_o}, 32'h1);
        chk("R6 irq not set while disabled", {31'b0, irq_o}, 32'h0);
        wait_edges(15);
        chk("R9 reset held through 16th clock", {31'b0, rst_req_o}, 32'h1);
        wait_edges(1);
        chk("R9 reset released after 16 clocks", {31'b0, rst_req_o}, 32'h0);
        chk("R9 reset pulse length", 32'(rst_seen - base), 32'd16);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_keepalive();
        int base;
        base = rst_seen;
        wr(A_RLD, 32'd4);
        wr(A_CNT, 32'd4);
        wr(A_CTRL, 32'h21);
        for (int i = 0; i < 10; i++) begin
            wait_edges(60);
            wr(A_CNT, 32'd4);
        end
        chk("R10 refreshed watchdog never resets", 32'(rst_seen - base), 32'd0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int base;
        base = rst_seen;
        wr(A_RLD, 32'd1);
        wr(A_CNT, 32'd1);
        wr(A_CTRL, 32'h25);
        wait_edges(20);
        wr(A_CTRL, 32'h0);
        wait_edges(200);
        chk("R11 stopped watchdog no reset", 32'(rst_seen - base), 32'd0);
        chk("R11 stopped watchdog no irq", {31'b0, irq_o}, 32'h0);
        rd(A_CNT, v); chk("R3 counter frozen after stop", v, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        rst_n = 1'b1;
        wait_edges(2);
        t_reset_state();
        t_readback();
        t_frozen();
        t_basic_expiry();
        t_irq_clear();
        t_prescale();
        t_div128();
        t_reset_pulse();
        t_keepalive();
        t_stop();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule